// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block keeps a free-running count of microseconds for the rest of the chip. The reference clock can run at one of several rates, some of them not a whole number of megahertz. A fractional accumulator scales the reference down to an average 1 MHz step. On every reference cycle the accumulator adds a programmed dividend. When the sum reaches the programmed divisor, the divisor is taken off and the count advances by one.

Software sets the ratio through a configuration word and reads the count back through a plain register port. The port is a write strobe with an address, plus a read data bus that is combinational on the address. A freeze bit stops both the accumulator and the count without losing the fractional phase. Each time the count advances, a registered single-cycle tick is sent out for other timers to use.

Top module: `usec_timebase`

## Requirements
- R1: After reset the count reads 0, the configuration reads 0x0000_000B, the freeze bit reads 0 and `tick_o` is low.
- R2: The configuration register is at offset 0x14. Bits [7:0] hold divisor−1 and bits [15:8] hold dividend−1. A read returns the stored 16 bits with bits [31:16] at zero, and written bits [31:16] are discarded.
- R3: Take a configuration write with dividend ≤ divisor, followed by n more clock edges with no freeze. The count then has advanced by exactly floor(n·(dividend)/(divisor)).
- R4: A configuration write clears the accumulator. No step happens on the edge that takes the write.
- R5: The standard settings each give one step per microsecond of reference time: 0x000B at 12 MHz, 0x000C at 13 MHz, 0x0019 at 26 MHz and 0x045F at 19.2 MHz.
- R6: The count is read at offset 0x10. It only ever changes by +1 and wraps modulo 2^CNT_W.
- R7: `tick_o` is high for exactly the cycles that follow an edge on which the count advanced, so the number of pulses equals the number of increments.
- R8: Bit 0 at offset 0x4c is the freeze bit, and it can be read back. From the edge after it is set, the accumulator and the count hold, no tick is issued, and reads return the held count. Clearing it resumes from the held fractional phase.
- R9: Writes to the count offset and to unmapped offsets change no state. Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i` (combinational) |
| tick_o | output | 1 | One-cycle pulse after each count increment |

## Verification
Some properties are checked on every cycle: the count only moves by one, each tick matches an increment, the accumulator and count hold while frozen, the accumulator clears on a configuration write, and the accumulator stays below the divisor. The arithmetic step rate across many ratios is shown only by the bench scenarios, which include the four standard reference settings, a sweep over small dividend/divisor pairs and the fractional phase kept across a freeze. Wraparound, register readback and ignored writes are also shown only by the bench; wraparound uses a second, narrow-count instance.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
  localparam logic [7:0]  OFF_COUNT  = 8'h10;
  localparam logic [7:0]  OFF_CFG    = 8'h14;
  localparam logic [7:0]  OFF_FREEZE = 8'h4c;
  localparam logic [15:0] CFG_RESET  = 16'h000B;
endpackage

// File: rtl/usec_regs.sv
module usec_regs
  import usec_timebase_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  localparam int CFG_W  = 2 * FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              freeze_o,
  output logic              cfg_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_cfg, sel_frz, sel_cnt;
  logic unused_wdata;

  assign sel_cnt = addr_i == ADDR_W'(OFF_COUNT);
  assign sel_cfg = addr_i == ADDR_W'(OFF_CFG);
  assign sel_frz = addr_i == ADDR_W'(OFF_FREEZE);
  assign cfg_wr_o = wr_en_i && sel_cfg;
  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= CFG_W'(CFG_RESET);
      freeze_o <= 1'b0;
    end else if (wr_en_i) begin
      if (sel_cfg) cfg_o    <= wdata_i[CFG_W-1:0];
      if (sel_frz) freeze_o <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_cnt)      rdata_o = DATA_W'(count_i);
    else if (sel_cfg) rdata_o = DATA_W'(cfg_o);
    else if (sel_frz) rdata_o = DATA_W'(freeze_o);
  end
endmodule

// File: rtl/usec_frac_prescaler.sv
module usec_frac_prescaler #(
  parameter int FIELD_W = 8,
  localparam int ACC_W  = FIELD_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FIELD_W-1:0] dividend_m1_i,
  input  logic [FIELD_W-1:0] divisor_m1_i,
  input  logic               freeze_i,
  input  logic               clear_i,
  output logic               step_o,
  output logic [ACC_W-1:0]   acc_o
);
  logic [ACC_W-1:0] inc, modulus, sum;

  assign inc     = ACC_W'(dividend_m1_i) + ACC_W'(1);
  assign modulus = ACC_W'(divisor_m1_i) + ACC_W'(1);
  assign sum     = acc_o + inc;
  assign step_o  = !freeze_i && !clear_i && (sum >= modulus);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_o <= '0;
    else if (clear_i)  acc_o <= '0;
    else if (freeze_i) acc_o <= acc_o;
    else if (step_o)   acc_o <= sum - modulus;
    else               acc_o <= sum;
  end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      tick_o  <= 1'b0;
    end else begin
      count_o <= count_o + CNT_W'(step_i);
      tick_o  <= step_i;
    end
  end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  localparam int CFG_W  = 2 * FIELD_W,
  localparam int ACC_W  = FIELD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             freeze_q;
  logic             cfg_wr;
  logic             step;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] count_q;

  usec_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .count_i(count_q), .cfg_o(cfg_q), .freeze_o(freeze_q),
    .cfg_wr_o(cfg_wr), .rdata_o(rdata_o)
  );

  usec_frac_prescaler #(.FIELD_W(FIELD_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dividend_m1_i(cfg_q[CFG_W-1:FIELD_W]), .divisor_m1_i(cfg_q[FIELD_W-1:0]),
    .freeze_i(freeze_q), .clear_i(cfg_wr), .step_o(step), .acc_o(acc_q)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step),
    .count_o(count_q), .tick_o(tick_o)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
  import usec_timebase_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int FIELD_W = 8,
  parameter int CNT_W   = 32,
  localparam int CFG_W  = 2 * FIELD_W,
  localparam int ACC_W  = FIELD_W + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              tick_i,
  input logic              freeze_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [CNT_W-1:0]  count_i
);
  logic cfg_ok;
  assign cfg_ok = cfg_i[CFG_W-1:FIELD_W] <= cfg_i[FIELD_W-1:0];

  p_step_by_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != $past(count_i)) |-> (count_i == $past(count_i) + CNT_W'(1)));

  p_tick_on_incr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (count_i != $past(count_i)));

  p_no_tick_still_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> $stable(count_i));

  p_freeze_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> ($stable(count_i) && $stable(acc_i) && !tick_i));

  p_cfg_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(OFF_CFG)) |=> (acc_i == '0 && !tick_i));

  p_acc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ok |-> (acc_i <= ACC_W'(cfg_i[FIELD_W-1:0])));
endmodule

bind usec_timebase usec_timebase_chk #(
  .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .tick_i(tick_o), .freeze_i(freeze_q), .cfg_i(cfg_q), .acc_i(acc_q),
  .count_i(count_q)
);

// File: tb/usec_timebase_tb.sv
module usec_timebase_tb;
  localparam int SW = 6;
  localparam logic [7:0] A_CNT = 8'h10, A_CFG = 8'h14, A_FRZ = 8'h4c, A_NONE = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic        tick, tick_w;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  usec_timebase u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
  );

  usec_timebase #(.CNT_W(SW)) u_dut_w (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_w), .tick_o(tick_w)
  );

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // called in the low phase of the clock
  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dw);
    addr = a;
    #1;
    d  = rdata;
    dw = rdata_w;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(input string req, input logic [15:0] cfg, input int n);
    logic [31:0] b, bw, c, cw;
    longint inc, md, adv;
    int ticks;
    rd(A_CNT, b, bw);
    wr(A_CFG, {16'h0, cfg});
    ticks = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick) ticks++;
    end
    rd(A_CNT, c, cw);
    inc = longint'(cfg[15:8]) + 1;
    md  = longint'(cfg[7:0]) + 1;
    adv = (longint'(n) * inc) / md;
    chk(req, c, (b + adv) & 64'hFFFF_FFFF);
    chk({req, " R7 ticks"}, ticks, adv);
    chk({req, " R6 narrow"}, cw, (bw + adv) % (1 << SW));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, dw, b, bw;
    bit moved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CNT, d, dw); chk("R1 count", d, 0);
    rd(A_CFG, d, dw); chk("R1 cfg", d, 32'h0000_000B);
    rd(A_FRZ, d, dw); chk("R1 freeze", d, 0);
    chk("R1 tick", tick, 0);
    @(negedge clk);

    // R5 standard reference settings
    window("R5 12MHz", 16'h000B, 1200);
    window("R5 13MHz", 16'h000C, 1300);
    window("R5 26MHz", 16'h0019, 2600);
    window("R5 19.2MHz", 16'h045F, 960);
    window("R3 19.2MHz partial", 16'h045F, 100);

    // R3 sweep over small ratios, including ratio 1
    for (int v = 0; v < 8; v++)
      for (int q = 0; q <= v; q++)
        window("R3 sweep", {8'(q), 8'(v)}, 37);

    // R6 wrap on the narrow instance, one step per edge
    window("R6 wrap", 16'h0000, 100);
    window("R3 ratio one", 16'h0707, 70);

    // R2 readback, upper bits dropped
    wr(A_CFG, 32'hABCD_0102);
    rd(A_CFG, d, dw); chk("R2 cfg readback", d, 32'h0000_0102);

    // R4 accumulator restart: 12 edges to first step after write
    window("R4 clear", 16'h000B, 11);
    window("R4 clear boundary", 16'h000B, 12);

    // R8 freeze keeps fractional phase
    rd(A_CNT, b, bw);
    wr(A_CFG, 32'h0000_000B);
    repeat (4) @(negedge clk);
    wr(A_FRZ, 32'h1);
    moved = 1'b0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      rd(A_CNT, d, dw);
      if (tick || d != b) moved = 1'b1;
    end
    chk("R8 held while frozen", moved, 0);
    rd(A_FRZ, d, dw); chk("R8 freeze readback", d, 1);
    wr(A_FRZ, 32'h0);
    repeat (6) @(negedge clk);
    rd(A_CNT, d, dw); chk("R8 phase kept, before step", d, b);
    @(negedge clk);
    rd(A_CNT, d, dw); chk("R8 phase kept, step", d, b + 1);

    // R9 ignored writes, one step per edge
    wr(A_CFG, 32'h0000_0000);
    rd(A_CNT, b, bw);
    wr(A_CNT, 32'hDEAD_BEEF);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_CNT, d, dw); chk("R9 count write ignored", d, b + 2);
    rd(A_CFG, d, dw); chk("R9 cfg untouched", d, 0);
    rd(A_FRZ, d, dw); chk("R9 freeze untouched", d, 0);
    rd(A_NONE, d, dw); chk("R9 unmapped read", d, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule